// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave that gives a host controller access to a small bank of configuration bytes. These bytes could hold settings such as clock frequency, output enables or drive strength. The block runs on a fast system clock. It samples SCL and SDA through synchronizers and finds bus edges itself. It pulls SDA low only through an open-drain output enable. It never stretches the clock.

The first byte after the address is a command byte. When bit 7 of the command is set, the transfer is an indexed single-byte access, and bits 6:0 give the register offset. When bit 7 is clear, the transfer is a block access that always starts at offset 0. A block write carries a byte count before its data. A block read returns a byte count before its data. A parallel local port reads and writes the same bank, so the surrounding logic always sees the current settings. At reset every register takes its default from a parameter, so the host may leave the bus unused.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address DEV_ADDR (default 7'b1101001, i.e. D2h for write, D3h for read). On any other address it never pulls SDA low and takes no action until the next START.
- R2: Command bit 7 = 1 selects byte mode with offset = command[6:0]. Command bit 7 = 0 selects block mode starting at offset 0. The slave acknowledges the command byte in both modes.
- R3: Byte write (address+W, command, one data byte, STOP) stores the data byte at the offset. Every byte is acknowledged.
- R4: Byte read (address+W, command, repeated START, address+R) returns the byte at the offset. The master NACKs it and sends STOP.
- R5: Block write (address+W, command 00h, count, data...) stores data bytes at offsets 0, 1, 2 and so on. The slave acknowledges the count byte and every data byte.
- R6: Block read (address+W, command 00h, repeated START, address+R) first returns the count NUM_REGS (08h by default), then returns bytes from offset 0 upward.
- R7: Every byte in both directions moves most significant bit first. The slave changes SDA only while SCL is low.
- R8: A STOP after any complete byte of a block write keeps the bytes already received. A STOP in the middle of a byte discards that byte.
- R9: On reset, register i holds REG_INIT[8i+7:8i].
- R10: A byte write to an offset at or above NUM_REGS is acknowledged but changes nothing. A byte read from such an offset returns 00h.
- R11: The local port reads register loc_addr_i combinationally. The local port writes on a clock edge when loc_we_i is high. A bus write to the same register in the same cycle takes priority. Bus and local accesses see each other's writes.
- R12: SDA is released (sda_oe_o = 0) during reset and in the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| loc_addr_i | input | AW | Local port register index |
| loc_we_i | input | 1 | Local port write strobe |
| loc_wdata_i | input | 8 | Local port write data |
| loc_rdata_o | output | 8 | Local port read data |

## Verification
The bench sweeps byte reads and writes over every offset, and runs full and truncated block transfers. It checks each acknowledge bit as well as each data bit. It aims at the count byte that leads a block read: a design that skips the count would shift every returned byte by one place. A STOP placed after three block bytes, and another placed four bits into a byte, catch a design that commits partial bytes or drops completed ones. Out-of-range offsets, a foreign address and local writes read back over the bus catch stray writes, a slave that answers an address that is not its own, and a bank shared wrongly between the two ports.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_TX,
    ST_IGNORE
  } stage_e;

  localparam int OFS_W = 7;
endpackage

// File: rtl/smbus_cfg_sync.sv
module smbus_cfg_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int STAGES = 2;

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smbus_cfg_regs.sv
module smbus_cfg_regs #(
  parameter int                  NUM_REGS = 8,
  parameter int                  AW       = 3,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [6:0]    bus_ofs_i,
  input  logic [7:0]    bus_wdata_i,
  input  logic [6:0]    bus_rofs_i,
  output logic [7:0]    bus_rdata_o,
  input  logic [AW-1:0] loc_addr_i,
  input  logic          loc_we_i,
  input  logic [7:0]    loc_wdata_i,
  output logic [7:0]    loc_rdata_o
);
  logic [7:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= REG_INIT[i*8 +: 8];
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (bus_we_i && int'(bus_ofs_i) == i) mem_q[i] <= bus_wdata_i;
        else if (loc_we_i && int'(loc_addr_i) == i) mem_q[i] <= loc_wdata_i;
      end
    end
  end

  // unmatched offsets read as zero
  always_comb begin
    bus_rdata_o = '0;
    loc_rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(bus_rofs_i) == i) bus_rdata_o = mem_q[i];
      if (int'(loc_addr_i) == i) loc_rdata_o = mem_q[i];
    end
  end

  p_bus_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && int'(bus_ofs_i) < NUM_REGS)
      |=> mem_q[$past(bus_ofs_i[AW-1:0])] == $past(bus_wdata_i))
    else $error("bus write not stored");
endmodule

// File: rtl/smbus_cfg_fsm.sv
module smbus_cfg_fsm
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [6:0] rd_ofs_o,
  output logic       wr_en_o,
  output logic [6:0] wr_ofs_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  stage_e     stage_q;
  logic [3:0] bit_cnt_q;
  logic       in_ack_q, block_q, m_nack_q;
  logic [7:0] rx_sh_q, tx_sh_q;
  logic [6:0] ptr_q;
  logic       rx_stage, byte_done;
  logic [2:0] tx_idx;

  assign rx_stage  = stage_q inside {ST_ADDR, ST_CMD, ST_CNT, ST_WDATA};
  assign byte_done = !in_ack_q && bit_cnt_q == 4'd8 && (rx_stage || stage_q == ST_TX);
  assign tx_idx    = 3'(4'd7 - bit_cnt_q);
  assign rd_ofs_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      block_q   <= 1'b0;
      m_nack_q  <= 1'b0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      ptr_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_ofs_o  <= '0;
      wr_data_o <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        stage_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        stage_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (scl_rise_i) begin
        if ((rx_stage || stage_q == ST_TX) && !in_ack_q && bit_cnt_q < 4'd8) begin
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (rx_stage) rx_sh_q <= {rx_sh_q[6:0], sda_i};
        end
        if (stage_q == ST_TX && in_ack_q) m_nack_q <= sda_i;
      end else if (scl_fall_i) begin
        if (byte_done) begin
          // eighth bit finished: open the acknowledge slot
          in_ack_q <= 1'b1;
          unique case (stage_q)
            ST_ADDR: begin
              if (rx_sh_q[7:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1;
                if (rx_sh_q[0]) begin
                  stage_q <= ST_TX;
                  if (block_q) tx_sh_q <= CNT_BYTE;
                  else begin
                    tx_sh_q <= rd_data_i;
                    ptr_q   <= ptr_q + 7'd1;
                  end
                end else begin
                  stage_q <= ST_CMD;
                end
              end else begin
                stage_q <= ST_IGNORE;
              end
            end
            ST_CMD: begin
              sda_oe_o <= 1'b1;
              block_q  <= ~rx_sh_q[7];
              ptr_q    <= rx_sh_q[7] ? rx_sh_q[6:0] : 7'd0;
              stage_q  <= rx_sh_q[7] ? ST_WDATA : ST_CNT;
            end
            ST_CNT: begin
              sda_oe_o <= 1'b1;
              stage_q  <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_oe_o  <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_ofs_o  <= ptr_q;
              wr_data_o <= rx_sh_q;
              ptr_q     <= ptr_q + 7'd1;
            end
            default: begin
              // transmit: release for master ack, fetch next byte
              sda_oe_o <= 1'b0;
              tx_sh_q  <= rd_data_i;
              ptr_q    <= ptr_q + 7'd1;
            end
          endcase
        end else if (in_ack_q) begin
          in_ack_q  <= 1'b0;
          bit_cnt_q <= '0;
          if (stage_q == ST_TX && !m_nack_q) sda_oe_o <= ~tx_sh_q[7];
          else begin
            sda_oe_o <= 1'b0;
            if (stage_q == ST_TX) stage_q <= ST_IGNORE;
          end
        end else if (stage_q == ST_TX && bit_cnt_q != 4'd0 && bit_cnt_q < 4'd8) begin
          sda_oe_o <= ~tx_sh_q[tx_idx];
        end
      end
    end
  end

  p_release_on_stop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o) else $error("SDA held after STOP");

  p_ignore_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_IGNORE) |-> !sda_oe_o) else $error("drive while ignoring");

  p_sda_moves_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_i)
    else $error("SDA changed with SCL high");

  p_bit_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd8) else $error("bit counter overrun");

  p_rx_ack_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q inside {ST_CMD, ST_CNT, ST_WDATA} && sda_oe_o) |-> in_ack_q)
    else $error("receive drive outside ack slot");
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter logic [6:0]            DEV_ADDR = 7'h69,
  parameter int                    NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = 64'h3CA5_00FF_8142_7E19,
  localparam int                   AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [AW-1:0] loc_addr_i,
  input  logic          loc_we_i,
  input  logic [7:0]    loc_wdata_i,
  output logic [7:0]    loc_rdata_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic       wr_en;
  logic [6:0] wr_ofs, rd_ofs;
  logic [7:0] wr_data, rd_data;

  smbus_cfg_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  smbus_cfg_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .rd_data_i  (rd_data),
    .rd_ofs_o   (rd_ofs),
    .wr_en_o    (wr_en),
    .wr_ofs_o   (wr_ofs),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  smbus_cfg_regs #(
    .NUM_REGS (NUM_REGS),
    .AW       (AW),
    .REG_INIT (REG_INIT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (wr_en),
    .bus_ofs_i   (wr_ofs),
    .bus_wdata_i (wr_data),
    .bus_rofs_i  (rd_ofs),
    .bus_rdata_o (rd_data),
    .loc_addr_i  (loc_addr_i),
    .loc_we_i    (loc_we_i),
    .loc_wdata_i (loc_wdata_i),
    .loc_rdata_o (loc_rdata_o)
  );
endmodule

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;
  localparam int Q = 10;
  localparam int N = 8;
  localparam logic [63:0] INIT = 64'h3CA5_00FF_8142_7E19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_low = 1'b0;
  logic       sda_oe;
  logic [2:0] loc_addr = '0;
  logic       loc_we = 1'b0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  wire        sda_w = ~(sda_low | sda_oe);

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [N];

  always #2.5 clk = ~clk;

  smbus_cfg_slave uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_w),
    .sda_oe_o    (sda_oe),
    .loc_addr_i  (loc_addr),
    .loc_we_i    (loc_we),
    .loc_wdata_i (loc_wdata),
    .loc_rdata_o (loc_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_low = 1'b0; tick(Q);
    scl_m = 1'b1;   tick(Q);
    sda_low = 1'b1; tick(Q);
    scl_m = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; tick(Q);
    scl_m = 1'b1;   tick(Q);
    sda_low = 1'b0; tick(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_low = ~b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_low = 1'b0; tick(Q);
    scl_m = 1'b1;   tick(Q);
    b = sda_w;      tick(Q);
    scl_m = 1'b0;   tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(last);
  endtask

  task automatic loc_read(input int a, output logic [7:0] d);
    loc_addr = 3'(a); tick(1);
    d = loc_rdata;
  endtask

  task automatic byte_write(input logic [6:0] ofs, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, ofs}, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_read(input logic [6:0] ofs, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, ofs}, a1);
    bus_start();
    send_byte(8'hD3, a2);
    recv_byte(1'b1, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    logic [7:0] d;
    logic ok, a;
    for (int i = 0; i < N; i++) model[i] = INIT[i*8 +: 8];
    tick(5);
    chk("R12 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);

    // R9 defaults via local port
    for (int i = 0; i < N; i++) begin
      loc_read(i, d);
      chk("R9 default", 32'(d), 32'(model[i]));
    end

    // R4 R2 byte reads of defaults
    for (int i = 0; i < N; i++) begin
      byte_read(7'(i), d, ok);
      chk("R2 byte read ack", 32'(ok), 1);
      chk("R4 byte read data", 32'(d), 32'(model[i]));
    end

    // R3 byte writes, R11 local readback
    for (int i = 0; i < N; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 5) ^ 8'hC3;
      byte_write(7'(i), v, ok);
      model[i] = v;
      chk("R3 byte write ack", 32'(ok), 1);
      chk("R12 oe after stop", 32'(sda_oe), 0);
    end
    for (int i = 0; i < N; i++) begin
      loc_read(i, d);
      chk("R3 R11 local sees bus write", 32'(d), 32'(model[i]));
    end

    // R6 R7 block read: count then data
    begin
      logic [7:0] cnt;
      logic a0, a1, a2;
      bus_start();
      send_byte(8'hD2, a0);
      send_byte(8'h00, a1);
      bus_start();
      send_byte(8'hD3, a2);
      chk("R6 block read acks", 32'({a0, a1, a2}), 32'h7);
      recv_byte(1'b0, cnt);
      chk("R6 block count", 32'(cnt), N);
      for (int i = 0; i < N; i++) begin
        recv_byte(i == N - 1, d);
        chk("R6 R7 block read data", 32'(d), 32'(model[i]));
      end
      bus_stop();
    end

    // R5 full block write
    begin
      logic [N+2:0] acks;
      bus_start();
      send_byte(8'hD2, acks[0]);
      send_byte(8'h00, acks[1]);
      send_byte(8'(N), acks[2]);
      for (int i = 0; i < N; i++) begin
        send_byte(8'(i * 29 + 3), acks[3+i]);
        model[i] = 8'(i * 29 + 3);
      end
      bus_stop();
      chk("R5 block write acks", 32'(acks), 32'((1 << (N + 3)) - 1));
      for (int i = 0; i < N; i++) begin
        loc_read(i, d);
        chk("R5 block write data", 32'(d), 32'(model[i]));
      end
    end

    // R8 block write cut after three complete bytes
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'(N), a);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(i * 11 + 8'h60), a);
      model[i] = 8'(i * 11 + 8'h60);
    end
    bus_stop();
    for (int i = 0; i < N; i++) begin
      loc_read(i, d);
      chk("R8 truncated block", 32'(d), 32'(model[i]));
    end

    // R8 STOP in the middle of a byte
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h83, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    loc_read(3, d);
    chk("R8 partial byte dropped", 32'(d), 32'(model[3]));

    // R10 out-of-range offsets
    byte_write(7'h40, 8'h99, ok);
    chk("R10 oor write ack", 32'(ok), 1);
    for (int i = 0; i < N; i++) begin
      loc_read(i, d);
      chk("R10 oor write discarded", 32'(d), 32'(model[i]));
    end
    byte_read(7'(N), d, ok);
    chk("R10 oor read zero", 32'(d), 0);
    byte_read(7'h7F, d, ok);
    chk("R10 oor read zero top", 32'(d), 0);

    // R1 foreign address
    for (int k = 0; k < 4; k++) begin
      logic [7:0] adr;
      logic a0, a1, a2;
      adr = (k == 0) ? 8'hA4 : (k == 1) ? 8'hD0 : (k == 2) ? 8'hD6 : 8'h52;
      bus_start();
      send_byte(adr, a0);
      send_byte(8'h80, a1);
      send_byte(8'hEE, a2);
      bus_stop();
      chk("R1 no ack foreign", 32'({a0, a1, a2}), 0);
    end
    loc_read(0, d);
    chk("R1 foreign write ignored", 32'(d), 32'(model[0]));

    // R11 local write seen over bus
    for (int i = 0; i < N; i++) begin
      loc_addr = 3'(i); loc_wdata = 8'(8'hF0 - i * 13); loc_we = 1'b1;
      tick(1);
      loc_we = 1'b0;
      model[i] = 8'(8'hF0 - i * 13);
    end
    for (int i = 0; i < N; i += 3) begin
      byte_read(7'(i), d, ok);
      chk("R11 bus sees local write", 32'(d), 32'(model[i]));
    end
    chk("R12 idle released", 32'(sda_oe), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule